// File: doc/BRIEF.md
# Square Wave Tone Channel

This block generates one programmable square-wave voice. Four byte-wide write registers set its duty pattern, volume, envelope, frequency sweep, 11-bit period and note length. A period timer steps an eight-position duty sequencer. A length counter gates the note. An envelope either holds a constant volume or decays from 15. A sweep unit can bend the period up or down on each half-frame tick. The output is a 4-bit amplitude together with a flag that shows whether the note length is still running.

An external frame sequencer provides a half-rate timer tick, a quarter-frame tick for the envelope and a half-frame tick for the length counter and the sweep. Each tick is a one-cycle-wide enable in the block's clock domain. Register writes are single-cycle strobes with no back-pressure: a write is always accepted in the cycle its strobe is high, so no ready signal exists. The control and status pins are plain levels. The parameter `NEG_TWOS` chooses the sweep negate arithmetic, so one design serves both channel instances.

Top module: `sq_tone_chan`

## Requirements
- R1: While `rst_n` is low, every counter and register clears to zero and the envelope start flag is set. After reset, `amp_out` is 0 and `len_active` is 0.
- R2: Each timer tick decrements the period divider. When the divider is already 0, the tick reloads it with the period and advances the duty step, which wraps from 7 to 0. The duty bit for step s is character s, read from the left, of the pattern for the duty field (bits 7:6 of register 0): 0→01000000, 1→01100000, 2→01111000, 3→10011111.
- R3: A write to register 3 does three things: it resets the duty step to 0, it restarts the envelope, and, only if `chan_en` is high, it loads the length counter from the table entry that its bits 7:3 index (index 0→10, index 3→2). Bits 2:0 of the write become period bits 10:8, and register 2 supplies period bits 7:0. The write leaves the timer divider unchanged.
- R4: While `chan_en` is low, the length counter is held at 0. A register 3 write in that state loads nothing.
- R5: On a half-frame tick, the length counter decrements when it is nonzero and the halt flag (register 0 bit 5) is clear. `len_active` shows that the counter is nonzero. `amp_out` is 0 whenever the counter is 0.
- R6: On a quarter-frame tick with the start flag set, the envelope loads its divider from register 0 bits 3:0, sets decay to 15 and clears the flag. Otherwise, when the divider is 0, the tick reloads the divider and decrements decay. With the loop flag (bit 5) set, decay wraps from 0 to 15. Without it, decay stays at 0.
- R7: When register 0 bit 4 is set, the amplitude is the constant value in bits 3:0. When it is clear, the amplitude is the envelope decay level.
- R8: `amp_out` is 0 when the period is below 8 or above 0x7FF, or when the current duty bit is 0.
- R9: On a half-frame tick, the sweep adds period >> shift to the period when all of these hold: its divider is 0, it is enabled (register 1 bit 7), the shift (bits 2:0) is nonzero, and the period is in 8..0x7FF. A result above 0x7FF mutes the channel.
- R10: When the negate flag (register 1 bit 3) is set, an instance with `NEG_TWOS`=0 changes the period to period − change − 1, and an instance with `NEG_TWOS`=1 changes it to period − change.
- R11: A register 1 write sets a reload flag. On each half-frame tick, the sweep divider reloads from bits 6:4 when it is 0 or the flag is set, and otherwise decrements. The tick clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select 0..3 |
| wr_data | input | 8 | Write data |
| tmr_tick | input | 1 | Half-rate timer enable |
| qtr_tick | input | 1 | Quarter-frame enable (envelope) |
| half_tick | input | 1 | Half-frame enable (length, sweep) |
| chan_en | input | 1 | Channel enable |
| amp_out | output | 4 | Channel amplitude |
| len_active | output | 1 | Length counter nonzero |

## Verification
The duty sequencer is tried with all four duty codes at several step positions. Each sample is chosen to separate one pattern from its neighbours, for example step 2 under codes 0 and 1, or step 0 under code 3. The length counter runs with table indices 0 and 3, once with halt clear and once with halt set, and under enable toggling. These runs separate a table error from a decrement error. The envelope is tried with periods 0 and 2 and with the loop flag on and off, which exposes divider-reload and wrap faults. The sweep is tried in add mode, in negate mode on both instances side by side, and with a nonzero divider period: an overflow mute, a one-unit difference at the 8 boundary and a skipped half-frame tick each show a different fault.

// File: rtl/sqt_pkg.sv
package sqt_pkg;
  localparam int LEN_W = 8;

  // Note length loaded by a register 3 write, indexed by bits 7:3.
  function automatic logic [LEN_W-1:0] len_lookup(input logic [4:0] idx);
    logic [LEN_W-1:0] v;
    if (idx[0]) begin
      v = (idx == 5'd1) ? 8'hFE : ({3'b000, idx} - 8'd1);
    end else begin
      case (idx[4:1])
        4'd0:  v = 8'h0A;
        4'd1:  v = 8'h14;
        4'd2:  v = 8'h28;
        4'd3:  v = 8'h50;
        4'd4:  v = 8'hA0;
        4'd5:  v = 8'h3C;
        4'd6:  v = 8'h0E;
        4'd7:  v = 8'h1A;
        4'd8:  v = 8'h0C;
        4'd9:  v = 8'h18;
        4'd10: v = 8'h30;
        4'd11: v = 8'h60;
        4'd12: v = 8'hC0;
        4'd13: v = 8'h48;
        4'd14: v = 8'h10;
        default: v = 8'h20;
      endcase
    end
    return v;
  endfunction

  // Waveform bit for a duty code at a step; bit s of the mask is step s.
  function automatic logic duty_bit(input logic [1:0] code, input logic [2:0] s);
    logic [7:0] mask;
    case (code)
      2'd0:    mask = 8'b0000_0010;
      2'd1:    mask = 8'b0000_0110;
      2'd2:    mask = 8'b0001_1110;
      default: mask = 8'b1111_1001;
    endcase
    return mask[s];
  endfunction
endpackage

// File: rtl/sqt_envelope.sv
module sqt_envelope (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qtr_tick,
  input  logic       restart,
  input  logic       loop_en,
  input  logic [3:0] period,
  output logic [3:0] decay,
  output logic       start_o
);
  logic [3:0] div_q;
  logic [3:0] decay_q;
  logic       start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      decay_q <= '0;
      start_q <= 1'b1;
    end else begin
      if (restart)                 start_q <= 1'b1;
      else if (qtr_tick && start_q) start_q <= 1'b0;
      if (qtr_tick) begin
        if (start_q) begin
          div_q   <= period;
          decay_q <= 4'hF;
        end else if (div_q != '0) begin
          div_q <= div_q - 4'd1;
        end else begin
          div_q <= period;
          if (decay_q != '0)  decay_q <= decay_q - 4'd1;
          else if (loop_en)   decay_q <= 4'hF;
        end
      end
    end
  end

  assign decay   = decay_q;
  assign start_o = start_q;
endmodule

// File: rtl/sqt_length.sv
module sqt_length import sqt_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             chan_en,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             halt,
  output logic             nonzero
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                   cnt_q <= '0;
    else if (!chan_en)                            cnt_q <= '0;
    else if (load)                                cnt_q <= load_val;
    else if (half_tick && !halt && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/sqt_sweep.sv
module sqt_sweep #(
  parameter int PW       = 12,
  parameter int PER_W    = 11,
  parameter int PER_MIN  = 8,
  parameter bit NEG_TWOS = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_tick,
  input  logic          reload_req,
  input  logic          enable,
  input  logic [2:0]    div_period,
  input  logic          negate,
  input  logic [2:0]    shift,
  input  logic [PW-1:0] period_in,
  output logic          apply_o,
  output logic [PW-1:0] period_next
);
  localparam logic [PW-1:0] LO = PW'(PER_MIN);
  localparam logic [PW-1:0] HI = PW'((1 << PER_W) - 1);

  logic [2:0]    div_q;
  logic          reload_q;
  logic [PW-1:0] change;
  logic [PW-1:0] neg_term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      if (reload_req)     reload_q <= 1'b1;
      else if (half_tick) reload_q <= 1'b0;
      if (half_tick) begin
        if (reload_q || div_q == '0) div_q <= div_period;
        else                         div_q <= div_q - 3'd1;
      end
    end
  end

  assign change = period_in >> shift;

  generate
    if (NEG_TWOS) begin : g_twos
      assign neg_term = ~change + PW'(1);
    end else begin : g_ones
      assign neg_term = ~change;
    end
  endgenerate

  assign period_next = period_in + (negate ? neg_term : change);
  assign apply_o = enable && (shift != '0) && (div_q == '0) &&
                   (period_in >= LO) && (period_in <= HI);
endmodule

// File: rtl/sq_tone_chan.sv
module sq_tone_chan import sqt_pkg::*; #(
  parameter int PER_W    = 11,
  parameter int PER_MIN  = 8,
  parameter bit NEG_TWOS = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       tmr_tick,
  input  logic       qtr_tick,
  input  logic       half_tick,
  input  logic       chan_en,
  output logic [3:0] amp_out,
  output logic       len_active
);
  localparam int HI_W = PER_W - 8;
  localparam int PW   = PER_W + 1;
  localparam logic [PW-1:0] LO = PW'(PER_MIN);
  localparam logic [PW-1:0] HI = PW'((1 << PER_W) - 1);

  logic [7:0]      ctl_q;
  logic [7:0]      swp_q;
  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  logic [PW-1:0]   per_q;
  logic [PW-1:0]   tcnt_q;
  logic [2:0]      step_q;

  logic wr0, wr1, wr2, wr3;
  assign wr0 = wr_en && (wr_sel == 2'd0);
  assign wr1 = wr_en && (wr_sel == 2'd1);
  assign wr2 = wr_en && (wr_sel == 2'd2);
  assign wr3 = wr_en && (wr_sel == 2'd3);

  logic          swp_apply;
  logic [PW-1:0] swp_next;
  logic [3:0]    env_decay;
  logic          env_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      swp_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      per_q <= '0;
    end else begin
      if (wr0) ctl_q <= wr_data;
      if (wr1) swp_q <= wr_data;
      if (wr2) lo_q  <= wr_data;
      if (wr3) hi_q  <= wr_data[HI_W-1:0];
      if (wr2)                         per_q <= {1'b0, hi_q, wr_data};
      else if (wr3)                    per_q <= {1'b0, wr_data[HI_W-1:0], lo_q};
      else if (half_tick && swp_apply) per_q <= swp_next;
    end
  end

  // Period divider and duty sequencer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      step_q <= '0;
    end else begin
      if (tmr_tick) begin
        if (tcnt_q == '0) tcnt_q <= per_q;
        else              tcnt_q <= tcnt_q - 1'b1;
      end
      if (wr3)                            step_q <= '0;
      else if (tmr_tick && tcnt_q == '0)  step_q <= step_q + 3'd1;
    end
  end

  sqt_envelope u_env (
    .clk     (clk),
    .rst_n   (rst_n),
    .qtr_tick(qtr_tick),
    .restart (wr3),
    .loop_en (ctl_q[5]),
    .period  (ctl_q[3:0]),
    .decay   (env_decay),
    .start_o (env_start)
  );

  sqt_length u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_tick(half_tick),
    .chan_en  (chan_en),
    .load     (wr3),
    .load_val (len_lookup(wr_data[7:3])),
    .halt     (ctl_q[5]),
    .nonzero  (len_active)
  );

  sqt_sweep #(
    .PW      (PW),
    .PER_W   (PER_W),
    .PER_MIN (PER_MIN),
    .NEG_TWOS(NEG_TWOS)
  ) u_swp (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .reload_req (wr1),
    .enable     (swp_q[7]),
    .div_period (swp_q[6:4]),
    .negate     (swp_q[3]),
    .shift      (swp_q[2:0]),
    .period_in  (per_q),
    .apply_o    (swp_apply),
    .period_next(swp_next)
  );

  logic muted;
  assign muted   = !len_active || (per_q < LO) || (per_q > HI) ||
                   !duty_bit(ctl_q[7:6], step_q);
  assign amp_out = muted ? 4'd0 : (ctl_q[4] ? ctl_q[3:0] : env_decay);
endmodule

// File: rtl/sq_tone_chan_chk.sv
module sq_tone_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       tmr_tick,
  input logic       qtr_tick,
  input logic       half_tick,
  input logic       chan_en,
  input logic [3:0] amp_out,
  input logic       len_active,
  input logic [2:0] step,
  input logic       env_start,
  input logic [3:0] decay
);
  assert_amp_needs_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_out != 4'd0) |-> len_active);

  assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !len_active);

  assert_len_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_active) |-> $past(wr_en && wr_sel == 2'd3 && chan_en));

  assert_step_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> (step == 3'd0));

  assert_env_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (qtr_tick && env_start && !(wr_en && wr_sel == 2'd3)) |=> (decay == 4'hF && !env_start));

  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tmr_tick && !qtr_tick && !half_tick && chan_en) |=> $stable(amp_out));
endmodule

bind sq_tone_chan sq_tone_chan_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .tmr_tick  (tmr_tick),
  .qtr_tick  (qtr_tick),
  .half_tick (half_tick),
  .chan_en   (chan_en),
  .amp_out   (amp_out),
  .len_active(len_active),
  .step      (step_q),
  .env_start (env_start),
  .decay     (env_decay)
);

// File: tb/sq_tone_chan_tb_top.sv
module sq_tone_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       tmr_tick = 1'b0;
  logic       qtr_tick = 1'b0;
  logic       half_tick = 1'b0;
  logic       chan_en = 1'b0;
  logic [3:0] amp_out, amp2;
  logic       len_active, len2;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sq_tone_chan #(.NEG_TWOS(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tmr_tick(tmr_tick), .qtr_tick(qtr_tick), .half_tick(half_tick),
    .chan_en(chan_en), .amp_out(amp_out), .len_active(len_active));

  sq_tone_chan #(.NEG_TWOS(1'b1)) dut2_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tmr_tick(tmr_tick), .qtr_tick(qtr_tick), .half_tick(half_tick),
    .chan_en(chan_en), .amp_out(amp2), .len_active(len2));

  // {duty code, steps advanced, expected amplitude with constant volume 9}
  localparam logic [8:0] VEC [13] = '{
    {2'd0, 3'd0, 4'd0}, {2'd0, 3'd1, 4'd9}, {2'd0, 3'd2, 4'd0},
    {2'd1, 3'd2, 4'd9}, {2'd1, 3'd3, 4'd0},
    {2'd2, 3'd4, 4'd9}, {2'd2, 3'd5, 4'd0}, {2'd2, 3'd1, 4'd9},
    {2'd3, 3'd0, 4'd9}, {2'd3, 3'd1, 4'd0}, {2'd3, 3'd2, 4'd0},
    {2'd3, 3'd3, 4'd9}, {2'd3, 3'd7, 4'd9}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tmr(input int n);
    if (n > 0) begin
      @(negedge clk); tmr_tick = 1'b1;
      repeat (n) @(negedge clk);
      tmr_tick = 1'b0;
    end
  endtask

  task automatic qtr(input int n);
    @(negedge clk); qtr_tick = 1'b1;
    repeat (n) @(negedge clk);
    qtr_tick = 1'b0;
  endtask

  task automatic half(input int n);
    @(negedge clk); half_tick = 1'b1;
    repeat (n) @(negedge clk);
    half_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset amp", amp_out, 0);
    chk("R1 reset len", len_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset amp", amp_out, 0);

    // Duty table walk: period 8, so 9 timer ticks per step.
    chan_en = 1'b1;
    wr(2'd2, 8'd8);
    wr(2'd1, 8'h00);
    for (int i = 0; i < 13; i++) begin
      wr(2'd0, {VEC[i][8:7], 2'b01, 4'd9});
      wr(2'd3, 8'h00);
      tmr(9 * int'(VEC[i][6:4]));
      chk($sformatf("R2 duty %0d step %0d", VEC[i][8:7], VEC[i][6:4]), amp_out, VEC[i][3:0]);
    end

    // R4 / R3: enable gating of the length load
    chan_en = 1'b0;
    wr(2'd0, 8'hD9);
    wr(2'd3, 8'h00);
    chk("R4 no load while disabled", len_active, 0);
    chan_en = 1'b1;
    wr(2'd3, 8'h00);
    chk("R3 load when enabled", len_active, 1);
    chk("R3 amp after load", amp_out, 9);
    @(negedge clk); chan_en = 1'b0;
    @(negedge clk);
    chk("R4 clear enable", len_active, 0);
    chan_en = 1'b1;

    // R5 length countdown, table index 0 -> 10, index 3 -> 2
    wr(2'd3, 8'h00);
    half(9);
    chk("R5 index0 after 9", len_active, 1);
    half(1);
    chk("R5 index0 after 10", len_active, 0);
    chk("R5 amp muted at len 0", amp_out, 0);
    wr(2'd3, 8'h18);
    half(1);
    chk("R5 index3 after 1", len_active, 1);
    half(1);
    chk("R5 index3 after 2", len_active, 0);
    wr(2'd0, 8'hF9);
    wr(2'd3, 8'h18);
    half(5);
    chk("R5 halt holds length", len_active, 1);

    // R6 envelope, period 0, no loop
    wr(2'd0, 8'hC0);
    wr(2'd3, 8'h00);
    qtr(1);
    chk("R6 start sets 15", amp_out, 15);
    qtr(15);
    chk("R6 decays to 0", amp_out, 0);
    qtr(1);
    chk("R6 no loop stays 0", amp_out, 0);
    wr(2'd0, 8'hE0);
    qtr(1);
    chk("R6 loop wraps to 15", amp_out, 15);
    wr(2'd0, 8'hC2);
    wr(2'd3, 8'h00);
    qtr(3);
    chk("R6 period 2 holds", amp_out, 15);
    qtr(1);
    chk("R6 period 2 step", amp_out, 14);

    // R7 constant volume, R8 low-period mute, R3 step reset
    wr(2'd0, 8'hD5);
    chk("R7 constant volume", amp_out, 5);
    wr(2'd2, 8'd7);
    chk("R8 period 7 muted", amp_out, 0);
    wr(2'd2, 8'd8);
    chk("R8 period 8 audible", amp_out, 5);
    tmr(9);
    chk("R2 duty3 step1 low", amp_out, 0);
    wr(2'd3, 8'h00);
    chk("R3 step reset to 0", amp_out, 5);

    // R9 sweep add with overflow mute
    wr(2'd0, 8'hF9);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h04);
    wr(2'd1, 8'h81);
    half(1);
    chk("R9 0x600 audible", amp_out, 9);
    half(1);
    chk("R9 0x900 muted", amp_out, 0);

    // R10 negate arithmetic per instance, period 9 shift 3
    wr(2'd2, 8'd9);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h8B);
    chk("R10 before sweep", amp_out, 9);
    half(1);
    chk("R10 ones complement -> 7", amp_out, 0);
    chk("R10 twos complement -> 8", amp2, 9);

    // R11 sweep divider period 1
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h04);
    wr(2'd1, 8'h91);
    half(2);
    chk("R11 skip on divider", amp_out, 9);
    half(1);
    chk("R11 apply after reload", amp_out, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule